// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets several processors exchange 32-bit words through six hardware queues that sit behind one word-addressed register bus. A processor posts a message by writing a channel's message register, and another processor takes the oldest queued message by reading the same register. Each channel also shows whether its queue is full and how many words it holds.

Four interrupt users watch the channels. Each user has a status register and an enable register. In both, every channel has a "message waiting" bit and a "space available" bit. A status bit is set by hardware while its condition holds and is cleared by writing 1 to it. Each user drives one level interrupt: the OR of its status bits that are also enabled. A fixed identification word, a small idle-configuration register and a reset-done flag complete the map.

Bus accesses take one cycle. Read data is registered, so it appears on `rdata` in the cycle after `rd_en` is sampled. `rdata` is zero in any cycle that follows no read. Bits [1:0] of `addr` are ignored.

Top module: `ipc_mailbox`

## Requirements
- R1: There are six channels. Channel n's message register is at byte offset 0x40+4n. A write appends a 32-bit word to that channel's queue, and a read removes and returns the oldest word, so words come out in first-in-first-out order.
- R2: Each queue holds 4 words. A write to a full queue is dropped and changes neither the stored words nor the count.
- R3: A read of an empty channel returns 0 and changes no state.
- R4: The register at 0x80+4n reads 1 while channel n's queue is full and 0 otherwise.
- R5: The register at 0xC0+4n returns the number of words queued in channel n (0 to 4). Zero means empty.
- R6: User u's status register is at 0x100+8u. Bit 2n is set on every cycle in which channel n is non-empty, and bit 2n+1 on every cycle in which channel n is not full. Bits 31:12 read 0.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the bit's condition still holds, the bit is set again one cycle after the clear.
- R8: User u's enable register is at 0x104+8u. Bits 11:0 are plain read/write and the upper bits read 0.
- R9: Interrupt output u is high exactly when some bit is set in both user u's status and user u's enable register. It is low whenever that enable register is zero.
- R10: Offset 0x00 returns the constant 0x00000020. At offset 0x10 only bits 0 and 4 can be written, and they read back as written. Offset 0x14 reads 1 once reset has completed.
- R11: Reads from unmapped offsets return 0 and writes to them are ignored. `rdata` is 0 in any cycle that follows no read.
- R12: After reset all queues are empty, all enable and configuration bits are 0 and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 9 | Byte offset of the access; bits [1:0] ignored |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after rd_en |
| irq_o | output | 4 | One level interrupt per user |

## Verification
The bound checker watches every cycle for these rules:
- No queue count ever exceeds the depth.
- A write to a full queue leaves its count at the depth.
- A read of an empty queue returns zero and leaves the count at zero.
- A status bit written with 1 is zero on the next cycle.
- No interrupt rises while its user's enable register is zero.
- Unmapped or absent reads yield zero data.

Only the directed scenarios can show the rest:
- The order and values of the words that come out of a queue.
- A dropped fifth word.
- A status bit that returns one cycle after it is cleared.
- An interrupt that rises and falls with queue traffic.
- The identification and configuration values.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int          MBX_NUM_CH   = 6;
  localparam int          MBX_NUM_USR  = 4;
  localparam int          MBX_DEPTH    = 4;
  localparam int          MBX_DATA_W   = 32;
  localparam int          MBX_ADDR_W   = 9;
  localparam logic [31:0] MBX_REVISION = 32'h0000_0020;
  localparam logic [31:0] MBX_CFG_BITS = 32'h0000_0011;

  // word indices (byte offset / 4)
  localparam int W_REV = 0;
  localparam int W_CFG = 4;
  localparam int W_SYS = 5;
  localparam int W_MSG = 16;
  localparam int W_FST = 32;
  localparam int W_MST = 48;
  localparam int W_IRQ = 64;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = empty ? '0 : mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    if (do_push && !do_pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (do_pop && !do_push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage has no reset; the count guards every read of it
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_ptr_q] <= din;
    end
  end
endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
  parameter int EVT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] events,
  input  logic             stat_we,
  input  logic             en_we,
  input  logic [EVT_W-1:0] wbits,
  output logic [EVT_W-1:0] stat,
  output logic [EVT_W-1:0] en,
  output logic             irq
);
  logic [EVT_W-1:0] stat_q, stat_d;
  logic [EVT_W-1:0] en_q, en_d;
  logic [EVT_W-1:0] clr;

  always_comb begin
    clr    = stat_we ? wbits : '0;
    stat_d = (stat_q | events) & ~clr;
    en_d   = en_we ? wbits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = |(stat_q & en_q);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int          NUM_CH   = MBX_NUM_CH,
  parameter int          NUM_USR  = MBX_NUM_USR,
  parameter int          DEPTH    = MBX_DEPTH,
  parameter int          DATA_W   = MBX_DATA_W,
  parameter int          ADDR_W   = MBX_ADDR_W,
  parameter logic [31:0] REVISION = MBX_REVISION
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_USR-1:0] irq_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int EVT_W  = 2 * NUM_CH;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [WORD_W-1:0]                word;
  logic                             unused_addr_lsb;
  logic [NUM_CH-1:0]                push, pop, full, empty;
  logic [NUM_CH-1:0][DATA_W-1:0]    fifo_dout;
  logic [NUM_CH-1:0][CNT_W-1:0]     fifo_cnt;
  logic [EVT_W-1:0]                 events;
  logic [NUM_USR-1:0]               stat_we, en_we;
  logic [NUM_USR-1:0][EVT_W-1:0]    stat_q, en_q;
  logic [DATA_W-1:0]                cfg_q, cfg_d;
  logic                             sys_done_q;
  logic [DATA_W-1:0]                rd_mux, rdata_q, rdata_d;

  assign word            = addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr[1:0];

  // bus decode into per-channel and per-user strobes
  always_comb begin
    push    = '0;
    pop     = '0;
    stat_we = '0;
    en_we   = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (int'(word) == W_MSG + n) begin
        push[n] = wr_en;
        pop[n]  = rd_en;
      end
    end
    for (int u = 0; u < NUM_USR; u++) begin
      if (int'(word) == W_IRQ + 2 * u)     stat_we[u] = wr_en;
      if (int'(word) == W_IRQ + 2 * u + 1) en_we[u]   = wr_en;
    end
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push[n]),
        .pop   (pop[n]),
        .din   (wdata),
        .dout  (fifo_dout[n]),
        .count (fifo_cnt[n]),
        .full  (full[n]),
        .empty (empty[n])
      );
      assign events[2*n]   = !empty[n];
      assign events[2*n+1] = !full[n];
    end
    for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
      mbx_irq_user #(.EVT_W(EVT_W)) u_user (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .stat_we (stat_we[u]),
        .en_we   (en_we[u]),
        .wbits   (wdata[EVT_W-1:0]),
        .stat    (stat_q[u]),
        .en      (en_q[u]),
        .irq     (irq_o[u])
      );
    end
  endgenerate

  // idle configuration and reset-done flag
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en && int'(word) == W_CFG) begin
      cfg_d = wdata & DATA_W'(MBX_CFG_BITS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      sys_done_q <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      sys_done_q <= 1'b1;
    end
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    if (int'(word) == W_REV) rd_mux = DATA_W'(REVISION);
    if (int'(word) == W_CFG) rd_mux = cfg_q;
    if (int'(word) == W_SYS) rd_mux = DATA_W'(sys_done_q);
    for (int n = 0; n < NUM_CH; n++) begin
      if (int'(word) == W_MSG + n) rd_mux = fifo_dout[n];
      if (int'(word) == W_FST + n) rd_mux = DATA_W'(full[n]);
      if (int'(word) == W_MST + n) rd_mux = DATA_W'(fifo_cnt[n]);
    end
    for (int u = 0; u < NUM_USR; u++) begin
      if (int'(word) == W_IRQ + 2 * u)     rd_mux = DATA_W'(stat_q[u]);
      if (int'(word) == W_IRQ + 2 * u + 1) rd_mux = DATA_W'(en_q[u]);
    end
  end

  assign rdata_d = rd_en ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int NUM_CH  = MBX_NUM_CH,
  parameter int NUM_USR = MBX_NUM_USR,
  parameter int DEPTH   = MBX_DEPTH,
  parameter int DATA_W  = MBX_DATA_W,
  parameter int ADDR_W  = MBX_ADDR_W,
  localparam int EVT_W  = 2 * NUM_CH,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             addr,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [DATA_W-1:0]             wdata,
  input logic [DATA_W-1:0]             rdata,
  input logic [NUM_USR-1:0]            irq_o,
  input logic [NUM_CH-1:0][CNT_W-1:0]  fifo_cnt,
  input logic [NUM_USR-1:0][EVT_W-1:0] stat_q,
  input logic [NUM_USR-1:0][EVT_W-1:0] en_q
);
  int  w;
  logic mapped;

  assign w = int'(addr[ADDR_W-1:2]);

  always_comb begin
    mapped = (w == W_REV) || (w == W_CFG) || (w == W_SYS)
          || (w >= W_MSG && w < W_MSG + NUM_CH)
          || (w >= W_FST && w < W_FST + NUM_CH)
          || (w >= W_MST && w < W_MST + NUM_CH)
          || (w >= W_IRQ && w < W_IRQ + 2 * NUM_USR);
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == '0));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk_ch
      assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt[n]) <= DEPTH);

      assert_full_write_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && w == W_MSG + n && int'(fifo_cnt[n]) == DEPTH)
        |=> (int'(fifo_cnt[n]) == DEPTH));

      assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && w == W_MSG + n && fifo_cnt[n] == '0)
        |=> (fifo_cnt[n] == '0 && rdata == '0));
    end
    for (genvar u = 0; u < NUM_USR; u++) begin : g_chk_usr
      assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w == W_IRQ + 2 * u)
        |=> ((stat_q[u] & $past(wdata[EVT_W-1:0])) == '0));

      assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[u] == '0) |-> !irq_o[u]);
    end
  endgenerate
endmodule

bind ipc_mailbox mbx_checker #(
  .NUM_CH (NUM_CH),
  .NUM_USR(NUM_USR),
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_mbx_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_o    (irq_o),
  .fifo_cnt (fifo_cnt),
  .stat_q   (stat_q),
  .en_q     (en_q)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic        clk;
  logic        rst_n;
  logic [8:0]  addr;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ipc_mailbox dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [8:0] a_msg(int n); return 9'(32'h40 + 4 * n); endfunction
  function automatic logic [8:0] a_fst(int n); return 9'(32'h80 + 4 * n); endfunction
  function automatic logic [8:0] a_mst(int n); return 9'(32'hC0 + 4 * n); endfunction
  function automatic logic [8:0] a_sts(int u); return 9'(32'h100 + 8 * u); endfunction
  function automatic logic [8:0] a_ena(int u); return 9'(32'h104 + 8 * u); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [8:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 irq after reset", 32'(irq_o), 32'h0);
    for (int n = 0; n < 6; n++) begin
      rd(a_mst(n), d); chk("R12 empty count", d, 32'h0);
    end
    rd(a_fst(0), d);  chk("R12 not full", d, 32'h0);
    rd(a_ena(0), d);  chk("R12 enable zero", d, 32'h0);
    rd(9'h010, d);    chk("R12 config zero", d, 32'h0);
    rd(a_sts(0), d);  chk("R6 space bits after reset", d, 32'h0000_0AAA);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(a_msg(1), 32'hA1A1_0001);
    wr(a_msg(1), 32'hB2B2_0002);
    wr(a_msg(1), 32'hC3C3_0003);
    rd(a_mst(1), d); chk("R5 count three", d, 32'd3);
    rd(a_msg(1), d); chk("R1 first out", d, 32'hA1A1_0001);
    rd(a_msg(1), d); chk("R1 second out", d, 32'hB2B2_0002);
    rd(a_msg(1), d); chk("R1 third out", d, 32'hC3C3_0003);
    rd(a_mst(1), d); chk("R5 count drained", d, 32'd0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) wr(a_msg(2), 32'hD000_0000 + 32'(i));
    rd(a_fst(2), d); chk("R4 full flag", d, 32'd1);
    rd(a_fst(3), d); chk("R4 other not full", d, 32'd0);
    rd(a_mst(2), d); chk("R2 count capped", d, 32'd4);
    for (int i = 0; i < 4; i++) begin
      rd(a_msg(2), d); chk("R2 kept word", d, 32'hD000_0000 + 32'(i));
    end
    rd(a_msg(2), d); chk("R2 fifth word dropped", d, 32'h0);
    rd(a_fst(2), d); chk("R4 full flag clear", d, 32'd0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    wr(a_msg(5), 32'h5555_AAAA);
    rd(a_msg(4), d); chk("R3 empty read zero", d, 32'h0);
    rd(a_mst(4), d); chk("R3 empty count kept", d, 32'h0);
    rd(a_msg(5), d); chk("R3 neighbour intact", d, 32'h5555_AAAA);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(a_msg(0), 32'h0000_00C0);
    wr(a_sts(1), 32'h0000_0FFF);
    idle(1);
    rd(a_sts(1), d); chk("R6 status after clear", d, 32'h0000_0AAB);
    wr(a_sts(1), 32'h0);
    rd(a_sts(1), d); chk("R7 write zero no effect", d, 32'h0000_0AAB);
    wr(a_sts(1), 32'h0000_0002);
    rd(a_sts(1), d); chk("R7 bit cleared", d, 32'h0000_0AA9);
    rd(a_sts(1), d); chk("R7 bit set again", d, 32'h0000_0AAB);
    rd(a_msg(0), d); chk("R1 ch0 word", d, 32'h0000_00C0);
    for (int i = 0; i < 4; i++) wr(a_msg(3), 32'h3300_0000 + 32'(i));
    wr(a_sts(0), 32'h0000_0FFF);
    idle(1);
    rd(a_sts(0), d); chk("R6 full channel bits", d, 32'h0000_0A6A);
    for (int i = 0; i < 4; i++) rd(a_msg(3), d);
    chk("R1 ch3 last word", d, 32'h3300_0003);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(a_ena(3), 32'hFFFF_FFFF);
    rd(a_ena(3), d); chk("R8 enable width", d, 32'h0000_0FFF);
    wr(a_ena(3), 32'h0000_0000);
    rd(a_ena(3), d); chk("R8 enable cleared", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(a_sts(2), 32'h0000_0FFF);
    wr(a_ena(2), 32'h0000_0040);
    idle(1);
    chk("R9 no event no irq", 32'(irq_o), 32'h0);
    wr(a_msg(3), 32'h0000_0303);
    idle(1);
    chk("R9 irq on message", 32'(irq_o), 32'h4);
    rd(a_msg(3), d);
    wr(a_sts(2), 32'h0000_0040);
    chk("R9 irq after ack", 32'(irq_o), 32'h0);
    wr(a_ena(2), 32'h0);
    wr(a_ena(3), 32'h0000_0002);
    chk("R9 space irq", 32'(irq_o), 32'h8);
    wr(a_ena(3), 32'h0);
    chk("R9 irq off with enable", 32'(irq_o), 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(9'h000, d); chk("R10 revision", d, 32'h0000_0020);
    rd(9'h014, d); chk("R10 reset done", d, 32'h1);
    wr(9'h010, 32'hFFFF_FFFF);
    rd(9'h010, d); chk("R10 config bits", d, 32'h0000_0011);
    wr(9'h010, 32'h0);
    rd(9'h010, d); chk("R10 config clear", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(9'h018, 32'hDEAD_BEEF);
    rd(9'h018, d); chk("R11 unmapped read", d, 32'h0);
    wr(9'h058, 32'h1234_5678);
    rd(9'h058, d); chk("R11 slot past channels", d, 32'h0);
    rd(a_mst(5), d); chk("R11 no stray push", d, 32'h0);
    rd(9'h120, d); chk("R11 past user regs", d, 32'h0);
    idle(1);
    chk("R11 idle rdata", rdata, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_empty();
    t_status();
    t_enable();
    t_irq();
    t_ident();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule